// File: doc/BRIEF.md
# Synchronous Burst SRAM Core

This block is a single-port synchronous memory of 32-bit words split into four byte lanes, meant to hold the data of a second-level cache. Every control and address input is taken on the rising clock edge. A cycle is opened by one of two start strobes. The processor-side strobe always opens a read. The controller-side strobe opens a read or a write. Later cycles either advance a two-bit burst offset or hold it, so a four-word block can be walked in linear or interleaved order without new addresses.

Writes are decoded from a global-write input, a byte-write enable and one write input per lane. Three chip selects must agree when a start strobe arrives, so that several devices can share a bus. Read data leaves either one edge after the access (flow-through) or two edges after it (pipelined), chosen by a mode pin. The output enable gates the drive without waiting for a clock. A sleep input freezes the block and keeps its contents. The bidirectional data bus is split here into `din`, `dout` and `dout_en`.

Top module: `sbs_sram`

## Requirements
- R1: The store holds 2**ADDR_W words of 32 bits (the default ADDR_W is 10; 16 gives 64K words). Lane i is bits 8i+7..8i of `din`/`dout`, and a lane write changes only that lane of the addressed word.
- R2: When `all_wr_n` is low, the cycle writes all four lanes, whatever `lane_wr_en_n` and `lane_wr_n` are.
- R3: When `all_wr_n` is high and `lane_wr_en_n` is low, lane i is written when `lane_wr_n[i]` is low. If all four `lane_wr_n` are high, the cycle is a read. When `all_wr_n` and `lane_wr_en_n` are both high, the cycle is a read.
- R4: A start selects the device only if `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. Any other combination deselects it: there is no access, the output stops driving, and no later continue cycle reads or writes until a new selected start.
- R5: `cpu_start_n` low while `sel_a_n` is low opens a read at `addr` and takes priority over `ctl_start_n`, even when the write inputs ask for a write. `cpu_start_n` is ignored while `sel_a_n` is high.
- R6: `ctl_start_n` low (when R5 does not apply) opens a cycle at `addr` that writes `din` if the write decode asks for it, and reads otherwise.
- R7: With both strobes inactive and a burst open, `step_n` low advances the burst offset by one and accesses the new address in that same cycle. `step_n` high accesses the current address again. In both cases the cycle reads or writes according to the decode in that cycle.
- R8: The two low address bits are base+offset mod 4 when `ilv_order` is 0 (linear) and base XOR offset when `ilv_order` is 1 (interleaved). The upper address bits stay at the start address, and the sequence wraps after four words.
- R9: With `pipe_mode`=0, read data drives the bus after the access edge until the next edge. With `pipe_mode`=1 it drives one edge later, so the bus turns on two edges after a selected read start and turns off one edge after a deselecting start.
- R10: `dout_en` is high only while a read result is due and `out_en_n` is low. It follows `out_en_n` without a clock. `dout` is zero whenever `dout_en` is low. Writes and deselected cycles never drive.
- R11: While `sleep` is high, clock edges change neither the store nor the burst state, and `dout_en` stays low. Stored data is kept, and operation resumes on the first edge with `sleep` low.
- R12: `rst_n` low clears the burst state and the read pipeline, so `dout_en` is low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of control state |
| sel_a_n | input | 1 | Chip select, active low; also qualifies `cpu_start_n` |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| cpu_start_n | input | 1 | Processor-side start strobe, always a read |
| ctl_start_n | input | 1 | Controller-side start strobe, read or write |
| step_n | input | 1 | Burst advance, active low |
| ilv_order | input | 1 | 1 = interleaved burst order, 0 = linear |
| pipe_mode | input | 1 | 1 = two-edge read latency, 0 = flow-through |
| addr | input | ADDR_W | Start address |
| all_wr_n | input | 1 | Global write, active low |
| lane_wr_en_n | input | 1 | Enables the per-lane write inputs, active low |
| lane_wr_n | input | 4 | Per-lane write, active low |
| din | input | 32 | Write data |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Standby request, active high |
| dout | output | 32 | Read data, zero when not driven |
| dout_en | output | 1 | Bus drive enable |

## Verification
The assertions take for granted that `pipe_mode` and `ilv_order` settle for a full cycle around each edge. They also assume that a read never reaches a word that has not been written, because unwritten words hold unknown values. The random stimulus therefore first fills a 64-word window with global writes, keeps every start address inside that window, and changes `pipe_mode` only every few hundred cycles. The directed cases read only words written just before.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  localparam int LANE_W = 8;

  typedef enum logic [1:0] {
    CYC_NONE  = 2'd0,
    CYC_CPU   = 2'd1,
    CYC_CTL   = 2'd2,
    CYC_CONT  = 2'd3
  } cyc_kind_e;
endpackage

// File: rtl/sbs_wr_decode.sv
module sbs_wr_decode #(
  parameter int LANES = 4
) (
  input  logic             all_wr_n,
  input  logic             lane_wr_en_n,
  input  logic [LANES-1:0] lane_wr_n,
  output logic [LANES-1:0] lanes
);
  // Global write wins; otherwise the lane enables are used only when qualified.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_comb begin
      if (!all_wr_n)          lanes[g] = 1'b1;
      else if (!lane_wr_en_n) lanes[g] = ~lane_wr_n[g];
      else                    lanes[g] = 1'b0;
    end
  end
endmodule

// File: rtl/sbs_cycle_ctl.sv
module sbs_cycle_ctl
  import sbs_pkg::*;
#(
  parameter int ADDR_W  = 10,
  parameter int BURST_W = 2,
  parameter int LANES   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep,
  input  logic              sel_a_n,
  input  logic              sel_b,
  input  logic              sel_c_n,
  input  logic              cpu_start_n,
  input  logic              ctl_start_n,
  input  logic              step_n,
  input  logic              ilv_order,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANES-1:0]  lanes_in,
  output logic              acc_valid,
  output logic              acc_write,
  output logic [ADDR_W-1:0] acc_addr,
  output logic [LANES-1:0]  acc_lanes,
  output cyc_kind_e         acc_kind
);
  localparam int HI_W = ADDR_W - BURST_W;

  logic              active_q, active_d;
  logic [ADDR_W-1:0] base_q, base_d;
  logic [BURST_W-1:0] off_q, off_d;

  logic               cpu_go, ctl_go, chips_ok, any_wr;
  logic [BURST_W-1:0] off_step, low_bits;
  logic [ADDR_W-1:0]  cont_addr;

  assign cpu_go   = !cpu_start_n && !sel_a_n;
  assign ctl_go   = !cpu_go && !ctl_start_n;
  assign chips_ok = !sel_a_n && sel_b && !sel_c_n;
  assign any_wr   = |lanes_in;
  assign off_step = step_n ? off_q : off_q + 1'b1;

  // Burst order: linear adds the offset, interleaved flips address bits.
  assign low_bits  = ilv_order ? (base_q[BURST_W-1:0] ^ off_step)
                               : (base_q[BURST_W-1:0] + off_step);
  assign cont_addr = {base_q[ADDR_W-1:BURST_W], low_bits};

  always_comb begin
    acc_valid = 1'b0;
    acc_write = 1'b0;
    acc_addr  = '0;
    acc_lanes = '0;
    acc_kind  = CYC_NONE;
    active_d  = active_q;
    base_d    = base_q;
    off_d     = off_q;
    if (!sleep) begin
      if (cpu_go || ctl_go) begin
        if (chips_ok) begin
          acc_valid = 1'b1;
          acc_addr  = addr;
          acc_kind  = cpu_go ? CYC_CPU : CYC_CTL;
          acc_write = ctl_go && any_wr;
          acc_lanes = ctl_go ? lanes_in : '0;
          active_d  = 1'b1;
          base_d    = addr;
          off_d     = '0;
        end else begin
          active_d  = 1'b0;
        end
      end else if (active_q) begin
        acc_valid = 1'b1;
        acc_addr  = cont_addr;
        acc_kind  = CYC_CONT;
        acc_write = any_wr;
        acc_lanes = lanes_in;
        off_d     = off_step;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      base_q   <= '0;
      off_q    <= '0;
    end else begin
      active_q <= active_d;
      base_q   <= base_d;
      off_q    <= off_d;
    end
  end

  logic unused_hi;
  assign unused_hi = (HI_W < 0);
endmodule

// File: rtl/sbs_store.sv
module sbs_store #(
  parameter int ADDR_W = 10,
  parameter int LANES  = 4
) (
  input  logic                      clk,
  input  logic                      acc_valid,
  input  logic                      acc_write,
  input  logic [ADDR_W-1:0]         acc_addr,
  input  logic [LANES-1:0]          acc_lanes,
  input  logic [LANES*sbs_pkg::LANE_W-1:0] wdata,
  output logic [LANES*sbs_pkg::LANE_W-1:0] rdata
);
  localparam int LW    = sbs_pkg::LANE_W;
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LW-1:0] mem [DEPTH];
    logic [LW-1:0] q;

    always_ff @(posedge clk) begin
      if (acc_valid && acc_write && acc_lanes[g])
        mem[acc_addr] <= wdata[g*LW +: LW];
      if (acc_valid && !acc_write)
        q <= mem[acc_addr];
    end

    assign rdata[g*LW +: LW] = q;
  end
endmodule

// File: rtl/sbs_read_path.sv
module sbs_read_path #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep,
  input  logic              rd_fire,
  input  logic [DATA_W-1:0] rdata,
  input  logic              pipe_mode,
  input  logic              out_en_n,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en
);
  logic              v1_q, v2_q;
  logic [DATA_W-1:0] d2_q;
  logic              due;
  logic [DATA_W-1:0] pick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1_q <= 1'b0;
      v2_q <= 1'b0;
    end else if (sleep) begin
      v1_q <= 1'b0;
      v2_q <= 1'b0;
    end else begin
      v1_q <= rd_fire;
      v2_q <= v1_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!sleep) d2_q <= rdata;
  end

  assign due     = pipe_mode ? v2_q : v1_q;
  assign pick    = pipe_mode ? d2_q : rdata;
  assign dout_en = due && !out_en_n && !sleep;
  assign dout    = dout_en ? pick : '0;
endmodule

// File: rtl/sbs_sram.sv
module sbs_sram
  import sbs_pkg::*;
#(
  parameter int ADDR_W  = 10,
  parameter int LANES   = 4,
  parameter int BURST_W = 2,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_a_n,
  input  logic              sel_b,
  input  logic              sel_c_n,
  input  logic              cpu_start_n,
  input  logic              ctl_start_n,
  input  logic              step_n,
  input  logic              ilv_order,
  input  logic              pipe_mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic              all_wr_n,
  input  logic              lane_wr_en_n,
  input  logic [LANES-1:0]  lane_wr_n,
  input  logic [DATA_W-1:0] din,
  input  logic              out_en_n,
  input  logic              sleep,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en
);
  logic [LANES-1:0]  lanes;
  logic              acc_valid, acc_write;
  logic [ADDR_W-1:0] acc_addr;
  logic [LANES-1:0]  acc_lanes;
  cyc_kind_e         acc_kind;
  logic [DATA_W-1:0] rdata;
  logic              rd_fire;

  sbs_wr_decode #(.LANES(LANES)) u_dec (
    .all_wr_n     (all_wr_n),
    .lane_wr_en_n (lane_wr_en_n),
    .lane_wr_n    (lane_wr_n),
    .lanes        (lanes)
  );

  sbs_cycle_ctl #(.ADDR_W(ADDR_W), .BURST_W(BURST_W), .LANES(LANES)) u_ctl (
    .clk         (clk),
    .rst_n       (rst_n),
    .sleep       (sleep),
    .sel_a_n     (sel_a_n),
    .sel_b       (sel_b),
    .sel_c_n     (sel_c_n),
    .cpu_start_n (cpu_start_n),
    .ctl_start_n (ctl_start_n),
    .step_n      (step_n),
    .ilv_order   (ilv_order),
    .addr        (addr),
    .lanes_in    (lanes),
    .acc_valid   (acc_valid),
    .acc_write   (acc_write),
    .acc_addr    (acc_addr),
    .acc_lanes   (acc_lanes),
    .acc_kind    (acc_kind)
  );

  sbs_store #(.ADDR_W(ADDR_W), .LANES(LANES)) u_store (
    .clk       (clk),
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .acc_addr  (acc_addr),
    .acc_lanes (acc_lanes),
    .wdata     (din),
    .rdata     (rdata)
  );

  assign rd_fire = acc_valid && !acc_write;

  sbs_read_path #(.DATA_W(DATA_W)) u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .sleep     (sleep),
    .rd_fire   (rd_fire),
    .rdata     (rdata),
    .pipe_mode (pipe_mode),
    .out_en_n  (out_en_n),
    .dout      (dout),
    .dout_en   (dout_en)
  );

  logic unused_kind;
  assign unused_kind = ^acc_kind;
endmodule

// File: rtl/sbs_sram_chk.sv
module sbs_sram_chk (
  input logic clk,
  input logic rst_n,
  input logic sleep,
  input logic out_en_n,
  input logic pipe_mode,
  input logic dout_en,
  input logic acc_valid,
  input logic acc_write,
  input logic cpu_start_n,
  input logic ctl_start_n,
  input logic sel_a_n,
  input logic sel_b,
  input logic sel_c_n
);
  logic acc_rd;
  assign acc_rd = acc_valid && !acc_write;

  p_cpu_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_start_n && !sel_a_n) |-> !acc_write);

  p_desel_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (((!cpu_start_n && !sel_a_n) || !ctl_start_n) && !(!sel_a_n && sel_b && !sel_c_n))
      |-> !acc_valid);

  p_sleep_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> (!acc_valid && !dout_en));

  p_flow_on_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(acc_rd) && !pipe_mode && !out_en_n && !sleep) |-> dout_en);

  p_pipe_on_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(rst_n, 2) && $past(acc_rd, 2) && !$past(sleep)
      && pipe_mode && !out_en_n && !sleep) |-> dout_en);

  p_pipe_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(rst_n, 2) && !$past(acc_rd, 2) && pipe_mode) |-> !dout_en);

  p_write_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(acc_valid && acc_write) && !pipe_mode) |-> !dout_en);
endmodule

bind sbs_sram sbs_sram_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sleep       (sleep),
  .out_en_n    (out_en_n),
  .pipe_mode   (pipe_mode),
  .dout_en     (dout_en),
  .acc_valid   (acc_valid),
  .acc_write   (acc_write),
  .cpu_start_n (cpu_start_n),
  .ctl_start_n (ctl_start_n),
  .sel_a_n     (sel_a_n),
  .sel_b       (sel_b),
  .sel_c_n     (sel_c_n)
);

// File: tb/sim_sbs_sram.sv
`timescale 1ns/1ps
module sim_sbs_sram;
  localparam int AW    = 10;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, sel_a_n, sel_b, sel_c_n, cpu_start_n, ctl_start_n, step_n;
  logic ilv_order, pipe_mode, all_wr_n, lane_wr_en_n, out_en_n, sleep;
  logic [3:0]    lane_wr_n;
  logic [AW-1:0] addr;
  logic [31:0]   din, dout;
  logic          dout_en;

  sbs_sram #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
    .cpu_start_n(cpu_start_n), .ctl_start_n(ctl_start_n), .step_n(step_n),
    .ilv_order(ilv_order), .pipe_mode(pipe_mode), .addr(addr), .all_wr_n(all_wr_n),
    .lane_wr_en_n(lane_wr_en_n), .lane_wr_n(lane_wr_n), .din(din),
    .out_en_n(out_en_n), .sleep(sleep), .dout(dout), .dout_en(dout_en)
  );

  int checks = 0;
  int errors = 0;

  logic [31:0]   ref_mem [DEPTH];
  logic          m_act, m_v1, m_v2;
  logic [AW-1:0] m_base;
  logic [1:0]    m_off;
  logic [31:0]   m_d1, m_d2;

  task automatic check_val(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  // Reference behaviour of one clock edge, from the requirements.
  task automatic model_edge();
    logic cpu_go, ctl_go, ok, hit, wr;
    logic [3:0] ln;
    logic [1:0] o;
    logic [AW-1:0] a;
    if (!rst_n) begin
      m_act = 0; m_v1 = 0; m_v2 = 0; m_base = '0; m_off = 0;
      return;
    end
    if (sleep) begin
      m_v1 = 0; m_v2 = 0;
      return;
    end
    ln = !all_wr_n ? 4'hF : (!lane_wr_en_n ? ~lane_wr_n : 4'h0);
    cpu_go = !cpu_start_n && !sel_a_n;
    ctl_go = !cpu_go && !ctl_start_n;
    ok = !sel_a_n && sel_b && !sel_c_n;
    hit = 0; wr = 0; a = '0;
    if (cpu_go || ctl_go) begin
      if (ok) begin
        hit = 1; a = addr; wr = ctl_go && (ln != 0);
        m_act = 1; m_base = addr; m_off = 0;
      end else m_act = 0;
    end else if (m_act) begin
      o = m_off + (step_n ? 2'd0 : 2'd1);
      m_off = o;
      a = {m_base[AW-1:2], ilv_order ? (m_base[1:0] ^ o) : (m_base[1:0] + o)};
      hit = 1; wr = (ln != 0);
    end
    m_v2 = m_v1; m_d2 = m_d1;
    if (hit && wr)
      for (int i = 0; i < 4; i++)
        if (ln[i]) ref_mem[a][8*i +: 8] = din[8*i +: 8];
    m_v1 = hit && !wr;
    if (m_v1) m_d1 = ref_mem[a];
  endtask

  task automatic check_model();
    logic e;
    logic [31:0] d;
    e = (pipe_mode ? m_v2 : m_v1) && !out_en_n && !sleep;
    d = e ? (pipe_mode ? m_d2 : m_d1) : 32'h0;
    check_val("R10 drive", {31'b0, dout_en}, {31'b0, e});
    if (e) check_val("R9 data", dout, d);
  endtask

  task automatic tick();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    if (rst_n) check_model();
  endtask

  task automatic set_idle();
    sel_a_n = 0; sel_b = 1; sel_c_n = 0;
    cpu_start_n = 1; ctl_start_n = 1; step_n = 1;
    all_wr_n = 1; lane_wr_en_n = 1; lane_wr_n = 4'hF;
    out_en_n = 0; sleep = 0;
  endtask

  task automatic ctl_write(logic [AW-1:0] a, logic [31:0] d);
    set_idle(); ctl_start_n = 0; all_wr_n = 0; addr = a; din = d;
    tick(); set_idle();
  endtask

  task automatic ctl_read(logic [AW-1:0] a);
    set_idle(); ctl_start_n = 0; addr = a;
    tick(); set_idle();
  endtask

  task automatic cont(logic stp, logic wr_all, logic [31:0] d);
    set_idle(); step_n = !stp; all_wr_n = !wr_all; din = d;
    tick(); set_idle();
  endtask

  task automatic deselect();
    set_idle(); ctl_start_n = 0; sel_b = 0;
    tick(); set_idle();
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL R12 watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    set_idle();
    rst_n = 0; ilv_order = 0; pipe_mode = 0; addr = '0; din = '0;
    m_d1 = '0; m_d2 = '0;
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
    repeat (3) tick();
    check_val("R12 reset drive", {31'b0, dout_en}, 32'd0);
    rst_n = 1;
    deselect();
    check_val("R12 idle after reset", {31'b0, dout_en}, 32'd0);

    // R2: global write ignores lane inputs
    set_idle(); ctl_start_n = 0; all_wr_n = 0; lane_wr_en_n = 1; lane_wr_n = 4'b1010;
    addr = 4; din = 32'h1122_3344; tick(); set_idle();
    ctl_read(4);
    check_val("R2 global write readback", dout, 32'h1122_3344);
    deselect();

    // R1/R3: single lane write
    set_idle(); ctl_start_n = 0; lane_wr_en_n = 0; lane_wr_n = 4'b1110;
    addr = 4; din = 32'hFFFF_FFAA; tick(); set_idle();
    ctl_read(4);
    check_val("R1 lane0 only", dout, 32'h1122_33AA);
    set_idle(); ctl_start_n = 0; lane_wr_en_n = 0; lane_wr_n = 4'b1111;
    addr = 4; din = 32'h0; tick(); set_idle();
    check_val("R3 all lanes high is read", dout, 32'h1122_33AA);
    set_idle(); ctl_start_n = 0; lane_wr_en_n = 1; lane_wr_n = 4'b0000;
    addr = 4; din = 32'h0; tick(); set_idle();
    check_val("R3 enable high is read", dout, 32'h1122_33AA);

    // R5: processor strobe is a read even with write inputs low
    set_idle(); cpu_start_n = 0; all_wr_n = 0; addr = 4; din = 32'hDEAD_BEEF;
    tick(); set_idle();
    check_val("R5 cpu start reads", dout, 32'h1122_33AA);
    deselect();

    // R6/R7: write burst 8..11
    ctl_write(8, 32'hB0);
    cont(1, 1, 32'hB1); cont(1, 1, 32'hB2); cont(1, 1, 32'hB3);
    deselect();
    // R8 linear from 9
    ilv_order = 0; ctl_read(9);
    check_val("R8 linear 1st", dout, 32'hB1);
    cont(1, 0, 0); check_val("R8 linear 2nd", dout, 32'hB2);
    cont(1, 0, 0); check_val("R8 linear 3rd", dout, 32'hB3);
    cont(1, 0, 0); check_val("R8 linear wrap", dout, 32'hB0);
    cont(0, 0, 0); check_val("R7 suspend holds", dout, 32'hB0);
    // R8 interleaved from 9
    ilv_order = 1; ctl_read(9);
    check_val("R8 ilv 1st", dout, 32'hB1);
    cont(1, 0, 0); check_val("R8 ilv 2nd", dout, 32'hB0);
    cont(1, 0, 0); check_val("R8 ilv 3rd", dout, 32'hB3);
    cont(1, 0, 0); check_val("R8 ilv 4th", dout, 32'hB2);
    ilv_order = 0;
    // R8 upper bits fixed at top of store
    ctl_write(DEPTH - 4, 32'hC0);
    cont(1, 1, 32'hC1); cont(1, 1, 32'hC2); cont(1, 1, 32'hC3);
    ctl_read(DEPTH - 1);
    check_val("R8 top 1st", dout, 32'hC3);
    cont(1, 0, 0); check_val("R8 top wrap", dout, 32'hC0);

    // R4: deselect stops access and later continues
    ctl_read(9);
    deselect();
    check_val("R4 deselect drive", {31'b0, dout_en}, 32'd0);
    cont(1, 1, 32'h0BAD_0BAD);
    check_val("R4 continue after deselect", {31'b0, dout_en}, 32'd0);
    set_idle(); cpu_start_n = 0; sel_c_n = 1; addr = 9; tick(); set_idle();
    check_val("R4 sel_c_n high", {31'b0, dout_en}, 32'd0);
    ctl_read(10);
    check_val("R4 no stray write", dout, 32'hB2);
    deselect();

    // R9 pipelined latency and turn-off
    pipe_mode = 1;
    deselect(); deselect();
    ctl_read(4);
    check_val("R9 pipe not yet", {31'b0, dout_en}, 32'd0);
    deselect();
    check_val("R9 pipe on", {31'b0, dout_en}, 32'd1);
    check_val("R9 pipe data", dout, 32'h1122_33AA);
    // R10 asynchronous output enable
    #0.5 out_en_n = 1; #0.5;
    check_val("R10 oe high off", {31'b0, dout_en}, 32'd0);
    check_val("R10 dout zero", dout, 32'd0);
    out_en_n = 0; #0.5;
    check_val("R10 oe low on", {31'b0, dout_en}, 32'd1);
    deselect();
    check_val("R9 pipe off", {31'b0, dout_en}, 32'd0);
    pipe_mode = 0;
    deselect();

    // R11 sleep ignores a write and keeps data
    set_idle(); sleep = 1; ctl_start_n = 0; all_wr_n = 0; addr = 4; din = 32'h5555_5555;
    tick();
    check_val("R11 sleep drive", {31'b0, dout_en}, 32'd0);
    tick(); set_idle();
    ctl_read(4);
    check_val("R11 data kept", dout, 32'h1122_33AA);

    // Random phase over a prefilled window
    for (int i = 0; i < 64; i++) ctl_write(AW'(i), $urandom);
    void'($urandom(32'h5EED_0001));
    for (int n = 0; n < 4000; n++) begin
      int r;
      if (n % 500 == 0) pipe_mode = $urandom_range(0, 1);
      set_idle();
      r = $urandom_range(0, 99);
      cpu_start_n = !(r < 15);
      ctl_start_n = !(r >= 15 && r < 40) && ($urandom_range(0, 9) != 0);
      sel_a_n = ($urandom_range(0, 19) == 0);
      sel_b   = ($urandom_range(0, 19) != 0);
      sel_c_n = ($urandom_range(0, 19) == 0);
      step_n  = $urandom_range(0, 1);
      ilv_order = $urandom_range(0, 1);
      all_wr_n = ($urandom_range(0, 99) >= 15);
      lane_wr_en_n = ($urandom_range(0, 99) >= 40);
      lane_wr_n = 4'($urandom);
      out_en_n = ($urandom_range(0, 99) >= 85);
      sleep = ($urandom_range(0, 99) < 5);
      addr = AW'($urandom_range(0, 63));
      din = $urandom;
      tick();
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule